// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Port

This block is the serial control port of a frequency synthesizer. An external controller drives three pins: a serial clock, a strobe and a data line. The data line is bidirectional, so at the block's edge it is split into an input, an output and an output enable. While the strobe is low, each rising edge of the serial clock shifts one data bit into a temporary register, most significant bit first. When the strobe rises, a word of exactly the right length is copied into one of four working registers. The word's own address field picks the register: the fraction word, the divider word, the control word or the test word.

The divider word does not change the active division ratio N straight away. Its N field waits in a holding register until the next fraction word is latched. At that point N and the new fraction take effect in the same cycle, and a one-cycle update strobe tells the modulator to pick up the new fraction. No reset goes to the modulator, so it carries on from its last state. A full setup is written as the control word, then the divider word, then the fraction word.

A test word with its read-request bit set starts a read-back. The read uses the strobe rise that latched the request. The first four serial clocks after that rise only prepare the output. The next nine serial clocks shift out the live N value, least significant bit first. A falling strobe returns the port to input mode at once, even in the middle of a read, and every read needs a new request. All three pins are synchronized into the fast system clock, and no logic runs on the serial clock itself.

Top module: `synth_prog_port`

## Requirements
- R1: A data bit is shifted in only on a rising serial clock edge while the strobe is low. Bits enter most significant first, so the last bit shifted is word bit 0. Serial clock edges while the strobe is high never change the word being assembled.
- R2: On a strobe rise, a word of exactly 24 bits is decoded by word bits [1:0]: 00 selects the fraction word, 01 the divider word, 10 the control word and 11 the test word. A word with 23, 25 or any other bit count leaves every working register unchanged.
- R3: A divider word loads word bits [10:2] into the N holding register and word bits [23:11] onto `b_aux_o` at once. `n_o` does not change.
- R4: A fraction word loads word bits [23:2] onto `frac_o`, copies the held N value to `n_o` in the same cycle, and raises `frac_upd_o` for exactly one system cycle. `frac_o` and `n_o` change in no other cycle.
- R5: A control word loads word bits [23:2] onto `c_word_o`. A test word loads word bits [23:2] onto `test_word_o`.
- R6: A test word with word bit 11 set arms a read at the strobe rise that latches it. The first four serial clock rises after that keep `bus_data_oe_o` low. A test word with bit 11 clear arms nothing.
- R7: After the fourth preparation rise, `bus_data_oe_o` is high for exactly nine serial clock periods. In the period before data rise k (k = 1..9), `bus_data_o` carries `n_o[k-1]`. After the ninth data rise, the output enable drops and the read is over. Later serial clocks do not re-enable the output.
- R8: A strobe fall drops `bus_data_oe_o` and cancels the armed read. A later strobe rise with no new request gives no output.
- R9: After reset every output is zero. Each output reacts to a pin change three system clock cycles later: two synchronizer stages, then one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Serial clock pin |
| bus_strobe_i | input | 1 | Strobe pin: low to shift, high to latch or read |
| bus_data_i | input | 1 | Data pin, input side |
| bus_data_o | output | 1 | Data pin, output side during a read |
| bus_data_oe_o | output | 1 | Output enable of the data pin |
| frac_o | output | 22 | Active fractional ratio |
| frac_upd_o | output | 1 | One-cycle pulse when a new fraction is active |
| n_o | output | 9 | Active division ratio N |
| b_aux_o | output | 13 | Upper fields of the divider word |
| c_word_o | output | 22 | Control word payload |
| test_word_o | output | 22 | Test word payload |

## Verification
The hardest states to reach are the read-back states. The request, the preparation count and the nine data periods all happen inside a single strobe-high window, and the stimulus must not drop the strobe until it has given the right number of serial clocks. The bench leaves the strobe high after a request word and then gives exact counts of serial clock pulses: the full thirteen, then extra pulses, and also a read cut short by a strobe fall after six pulses. It also sends words one bit short and one bit long, and sends several divider words before a fraction word, to show that the held N is applied only when the fraction word arrives.

// File: rtl/spp_pkg.sv
package spp_pkg;
  localparam int WORD_W      = 24;
  localparam int ADDR_W      = 2;
  localparam int N_W         = 9;
  localparam int PREP_CLKS   = 4;
  localparam int READ_BIT    = 11;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_FRAC = 2'b00,
    SEL_DIV  = 2'b01,
    SEL_CTRL = 2'b10,
    SEL_TEST = 2'b11
  } word_sel_e;
endpackage

// File: rtl/spp_sync.sv
module spp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], pin_i[gi]};
    end
    assign lvl_o[gi]  = chain[STAGES-1];
    assign rise_o[gi] = chain[STAGES-1] & ~chain[STAGES];
    assign fall_o[gi] = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/spp_shifter.sv
module spp_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              stb_lvl,
  input  logic              stb_rise,
  input  logic              din,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam int CNT_MAX = WORD_W + 1;

  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;

  assign word_valid_o = stb_rise && (bit_cnt == CNT_W'(WORD_W));
  assign word_o       = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (stb_rise) begin
      bit_cnt <= '0;
    end else if (!stb_lvl && sclk_rise) begin
      shreg <= {shreg[WORD_W-2:0], din};
      if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spp_regbank.sv
module spp_regbank
  import spp_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int N_W      = 9,
  parameter int READ_BIT = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       word_valid_i,
  input  logic [WORD_W-1:0]          word_i,
  output logic [WORD_W-ADDR_W-1:0]   frac_o,
  output logic                       frac_upd_o,
  output logic [N_W-1:0]             n_o,
  output logic [WORD_W-ADDR_W-N_W-1:0] b_aux_o,
  output logic [WORD_W-ADDR_W-1:0]   c_word_o,
  output logic [WORD_W-ADDR_W-1:0]   test_word_o,
  output logic                       arm_o
);
  localparam int P_W = WORD_W - ADDR_W;

  word_sel_e        sel;
  logic [P_W-1:0]   payload;
  logic [N_W-1:0]   n_held;

  assign sel     = word_sel_e'(word_i[ADDR_W-1:0]);
  assign payload = word_i[WORD_W-1:ADDR_W];
  assign arm_o   = word_valid_i && (sel == SEL_TEST) && word_i[READ_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_o      <= '0;
      frac_upd_o  <= 1'b0;
      n_o         <= '0;
      n_held      <= '0;
      b_aux_o     <= '0;
      c_word_o    <= '0;
      test_word_o <= '0;
    end else begin
      frac_upd_o <= 1'b0;
      if (word_valid_i) begin
        unique case (sel)
          SEL_FRAC: begin
            frac_o     <= payload;
            n_o        <= n_held;
            frac_upd_o <= 1'b1;
          end
          SEL_DIV: begin
            n_held  <= payload[N_W-1:0];
            b_aux_o <= payload[P_W-1:N_W];
          end
          SEL_CTRL: c_word_o    <= payload;
          SEL_TEST: test_word_o <= payload;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spp_readback.sv
module spp_readback #(
  parameter int N_W       = 9,
  parameter int PREP_CLKS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           arm_i,
  input  logic           sclk_rise,
  input  logic           stb_lvl,
  input  logic           stb_fall,
  input  logic [N_W-1:0] n_i,
  output logic           dout_o,
  output logic           oe_o
);
  localparam int LAST  = PREP_CLKS + N_W;
  localparam int RC_W  = $clog2(LAST + 1);
  localparam int IDX_W = (N_W > 1) ? $clog2(N_W) : 1;

  logic            armed;
  logic [RC_W-1:0] rise_cnt;
  logic [RC_W-1:0] offset;
  logic [IDX_W-1:0] idx;

  assign offset = rise_cnt - RC_W'(PREP_CLKS);
  assign idx    = offset[IDX_W-1:0];
  assign dout_o = oe_o ? n_i[idx] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      rise_cnt <= '0;
      oe_o     <= 1'b0;
    end else if (stb_fall) begin
      armed    <= 1'b0;
      rise_cnt <= '0;
      oe_o     <= 1'b0;
    end else if (arm_i) begin
      armed    <= 1'b1;
      rise_cnt <= '0;
      oe_o     <= 1'b0;
    end else if (armed && stb_lvl && sclk_rise) begin
      rise_cnt <= rise_cnt + 1'b1;
      if (rise_cnt + 1'b1 == RC_W'(PREP_CLKS)) oe_o <= 1'b1;
      if (rise_cnt + 1'b1 == RC_W'(LAST)) begin
        oe_o  <= 1'b0;
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port
  import spp_pkg::*;
#(
  parameter int WORD_W_P    = WORD_W,
  parameter int N_W_P       = N_W,
  parameter int PREP_P      = PREP_CLKS,
  parameter int READ_BIT_P  = READ_BIT,
  parameter int SYNC_P      = SYNC_STAGES
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 bus_clk_i,
  input  logic                                 bus_strobe_i,
  input  logic                                 bus_data_i,
  output logic                                 bus_data_o,
  output logic                                 bus_data_oe_o,
  output logic [WORD_W_P-ADDR_W-1:0]           frac_o,
  output logic                                 frac_upd_o,
  output logic [N_W_P-1:0]                     n_o,
  output logic [WORD_W_P-ADDR_W-N_W_P-1:0]     b_aux_o,
  output logic [WORD_W_P-ADDR_W-1:0]           c_word_o,
  output logic [WORD_W_P-ADDR_W-1:0]           test_word_o
);
  localparam int PIN_CLK = 2;
  localparam int PIN_STB = 1;
  localparam int PIN_DAT = 0;

  logic [2:0] pin_lvl, pin_rise, pin_fall;
  logic clk_rise, strobe_lvl, strobe_rise, strobe_fall, data_lvl;
  logic word_valid, arm;
  logic [WORD_W_P-1:0] word_q;

  spp_sync #(.W(3), .STAGES(SYNC_P)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin_i({bus_clk_i, bus_strobe_i, bus_data_i}),
    .lvl_o(pin_lvl), .rise_o(pin_rise), .fall_o(pin_fall)
  );

  assign clk_rise    = pin_rise[PIN_CLK];
  assign strobe_lvl  = pin_lvl[PIN_STB];
  assign strobe_rise = pin_rise[PIN_STB];
  assign strobe_fall = pin_fall[PIN_STB];
  assign data_lvl    = pin_lvl[PIN_DAT];

  spp_shifter #(.WORD_W(WORD_W_P)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(clk_rise), .stb_lvl(strobe_lvl), .stb_rise(strobe_rise),
    .din(data_lvl), .word_valid_o(word_valid), .word_o(word_q)
  );

  spp_regbank #(.WORD_W(WORD_W_P), .N_W(N_W_P), .READ_BIT(READ_BIT_P)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .word_valid_i(word_valid), .word_i(word_q),
    .frac_o(frac_o), .frac_upd_o(frac_upd_o), .n_o(n_o), .b_aux_o(b_aux_o),
    .c_word_o(c_word_o), .test_word_o(test_word_o), .arm_o(arm)
  );

  spp_readback #(.N_W(N_W_P), .PREP_CLKS(PREP_P)) u_read (
    .clk(clk), .rst_n(rst_n),
    .arm_i(arm), .sclk_rise(clk_rise), .stb_lvl(strobe_lvl), .stb_fall(strobe_fall),
    .n_i(n_o), .dout_o(bus_data_o), .oe_o(bus_data_oe_o)
  );
endmodule

// File: rtl/spp_checker.sv
module spp_checker #(
  parameter int P_W = 22,
  parameter int N_W = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           frac_upd_o,
  input logic [N_W-1:0] n_o,
  input logic [P_W-1:0] frac_o,
  input logic [P_W-1:0] c_word_o,
  input logic [P_W-1:0] test_word_o,
  input logic           bus_data_oe_o,
  input logic           strobe_fall,
  input logic           strobe_lvl,
  input logic           clk_rise,
  input logic           word_valid,
  input logic [1:0]     word_sel
);
  logic [7:0] oe_rises;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         oe_rises <= '0;
    else if (!bus_data_oe_o)            oe_rises <= '0;
    else if (clk_rise)                  oe_rises <= oe_rises + 1'b1;
  end

  AST_UPD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frac_upd_o |=> !frac_upd_o); // R4
  AST_UPD_FROM_FRAC_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    frac_upd_o |-> $past(word_valid && word_sel == 2'b00)); // R4
  AST_N_MOVES_WITH_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_o) |-> frac_upd_o); // R3
  AST_FRAC_MOVES_WITH_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frac_o) |-> frac_upd_o); // R4
  AST_REGS_HOLD_WITHOUT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |=> ($stable(c_word_o) && $stable(test_word_o))); // R5
  AST_FALL_DROPS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_fall |=> !bus_data_oe_o); // R8
  AST_OE_STARTS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_data_oe_o) |-> $past(clk_rise && strobe_lvl)); // R6
  AST_OE_NINE_PERIODS: assert property (@(posedge clk) disable iff (!rst_n)
    oe_rises <= 8'(N_W)); // R7
endmodule

bind synth_prog_port spp_checker #(.P_W(WORD_W_P - 2), .N_W(N_W_P)) u_chk (
  .clk(clk), .rst_n(rst_n), .frac_upd_o(frac_upd_o), .n_o(n_o), .frac_o(frac_o),
  .c_word_o(c_word_o), .test_word_o(test_word_o), .bus_data_oe_o(bus_data_oe_o),
  .strobe_fall(strobe_fall), .strobe_lvl(strobe_lvl), .clk_rise(clk_rise),
  .word_valid(word_valid), .word_sel(word_q[1:0])
);

// File: tb/synth_prog_port_bench.sv
module synth_prog_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, bstb = 1'b1, bdat = 1'b0;
  logic dout, doe, upd;
  logic [21:0] frac, cw, tw;
  logic [8:0]  nval;
  logic [12:0] aux;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  synth_prog_port u_synth_prog_port (
    .clk(clk), .rst_n(rst_n), .bus_clk_i(bclk), .bus_strobe_i(bstb), .bus_data_i(bdat),
    .bus_data_o(dout), .bus_data_oe_o(doe), .frac_o(frac), .frac_upd_o(upd),
    .n_o(nval), .b_aux_o(aux), .c_word_o(cw), .test_word_o(tw)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [2:0] hist[$];   // {clk, strobe, data} as seen at each system edge
  int m_cnt, m_rc;
  logic [23:0] m_sh;
  logic [21:0] m_frac, m_c, m_t;
  logic [8:0]  m_n, m_held;
  logic [12:0] m_aux;
  logic m_upd, m_armed, m_oe;

  task automatic model_reset();
    hist = '{3'b000, 3'b000, 3'b000, 3'b000};
    m_cnt = 0; m_rc = 0; m_sh = '0; m_frac = '0; m_c = '0; m_t = '0;
    m_n = '0; m_held = '0; m_aux = '0; m_upd = 0; m_armed = 0; m_oe = 0;
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      hist.push_back({bclk, bstb, bdat});
      void'(hist.pop_front());
    end
  end

  task automatic model_step();
    logic [2:0] pv, cu;
    logic crise, srise, sfall;
    pv = hist[0]; cu = hist[1];
    crise = cu[2] & ~pv[2];
    srise = cu[1] & ~pv[1];
    sfall = ~cu[1] & pv[1];
    m_upd = 0;
    if (sfall) begin m_armed = 0; m_rc = 0; m_oe = 0; end
    else if (m_armed && crise && cu[1]) begin
      m_rc++;
      if (m_rc == 4) m_oe = 1;
      if (m_rc == 13) begin m_oe = 0; m_armed = 0; end
    end
    if (srise) begin
      if (m_cnt == 24) begin
        case (m_sh[1:0])
          2'b00: begin m_frac = m_sh[23:2]; m_n = m_held; m_upd = 1; end
          2'b01: begin m_held = m_sh[10:2]; m_aux = m_sh[23:11]; end
          2'b10: m_c = m_sh[23:2];
          default: begin
            m_t = m_sh[23:2];
            if (m_sh[11]) begin m_armed = 1; m_rc = 0; m_oe = 0; end
          end
        endcase
      end
      m_cnt = 0;
    end else if (!cu[1] && crise) begin
      m_sh = {m_sh[22:0], cu[0]};
      if (m_cnt < 25) m_cnt++;
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) model_reset();
    else begin
      model_step();
      chk("R4 frac_o", 32'(frac), 32'(m_frac));
      chk("R4 frac_upd_o", 32'(upd), 32'(m_upd));
      chk("R3 n_o", 32'(nval), 32'(m_n));
      chk("R3 b_aux_o", 32'(aux), 32'(m_aux));
      chk("R5 c_word_o", 32'(cw), 32'(m_c));
      chk("R5 test_word_o", 32'(tw), 32'(m_t));
      chk("R6 bus_data_oe_o", 32'(doe), 32'(m_oe));
      chk("R7 bus_data_o", 32'(dout), m_oe ? 32'(m_n[m_rc-4]) : 32'd0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_bit(logic b);
    bdat = b; bclk = 1'b0; wait_cyc(4);
    bclk = 1'b1; wait_cyc(4);
  endtask

  task automatic send_word(logic [31:0] w, int nb);
    bstb = 1'b0; bclk = 1'b0; wait_cyc(6);
    for (int i = nb - 1; i >= 0; i--) bus_bit(w[i]);
    bclk = 1'b0; wait_cyc(4);
    bstb = 1'b1; wait_cyc(10);
  endtask

  // pulses with strobe high; capture data/oe just before each rise
  logic [15:0] cap_d, cap_oe;
  task automatic rd_pulses(int n);
    cap_d = '0; cap_oe = '0;
    for (int k = 1; k <= n; k++) begin
      bclk = 1'b0; wait_cyc(4);
      if (k <= 16) begin cap_d[k-1] = dout; cap_oe[k-1] = doe; end
      bclk = 1'b1; wait_cyc(4);
    end
    bclk = 1'b0; wait_cyc(6);
  endtask

  initial begin
    model_reset();
    wait_cyc(5);
    // R9 reset values
    chk("R9 reset n_o", 32'(nval), 0);
    chk("R9 reset frac_o", 32'(frac), 0);
    chk("R9 reset oe", 32'(doe), 0);
    rst_n = 1'b1;
    wait_cyc(8);

    // R1/R2 programming order C, B, A
    send_word({22'h2AA5C3, 2'b10}, 24);
    chk("R5 control word", 32'(cw), 32'h2AA5C3);
    send_word({13'h1ABC, 9'h1A5, 2'b01}, 24);
    chk("R3 aux immediate", 32'(aux), 32'h1ABC);
    chk("R3 n held back", 32'(nval), 0);
    send_word({22'h13579B, 2'b00}, 24);
    chk("R4 n applied", 32'(nval), 32'h1A5);
    chk("R4 fraction applied", 32'(frac), 32'h13579B);

    // R2 wrong bit counts discarded
    send_word({1'b0, 22'h0F0F0F, 2'b10}, 23);
    chk("R2 short word ignored", 32'(cw), 32'h2AA5C3);
    send_word({1'b1, 22'h3C3C3C, 2'b10}, 25);
    chk("R2 long word ignored", 32'(cw), 32'h2AA5C3);

    // R1 clocks while strobe high do not shift
    rd_pulses(5);
    send_word({22'h111111, 2'b10}, 24);
    chk("R1 shift only while low", 32'(cw), 32'h111111);

    // two divider words, then fraction: last held N wins
    send_word({13'h0001, 9'h0F3, 2'b01}, 24);
    send_word({13'h0002, 9'h14E, 2'b01}, 24);
    chk("R3 n still old", 32'(nval), 32'h1A5);
    send_word({22'h000001, 2'b00}, 24);
    chk("R4 latest held n", 32'(nval), 32'h14E);

    // R6/R7 full read
    send_word(32'h000803, 24);
    rd_pulses(15);
    chk("R6 prep no oe", 32'(cap_oe[3:0]), 0);
    chk("R7 oe nine periods", 32'(cap_oe[12:4]), 32'h1FF);
    chk("R7 data lsb first", 32'(cap_d[12:4]), 32'h14E);
    chk("R7 oe off after read", 32'(cap_oe[14:13]), 0);

    // R6 test word without request bit
    send_word(32'h000003, 24);
    rd_pulses(14);
    chk("R6 no request no output", 32'(cap_oe[13:0]), 0);

    // R8 aborted read and fresh request needed
    send_word({13'h0000, 9'h0B7, 2'b01}, 24);
    send_word({22'h2FFFFF, 2'b00}, 24);
    send_word(32'h000803, 24);
    rd_pulses(6);
    chk("R8 oe during read", 32'(cap_oe[5:4]), 32'h3);
    bstb = 1'b0; wait_cyc(4);
    chk("R8 fall drops oe", 32'(doe), 0);
    bstb = 1'b1; wait_cyc(6);
    rd_pulses(14);
    chk("R8 no output without request", 32'(cap_oe[13:0]), 0);
    send_word(32'h000803, 24);
    rd_pulses(13);
    chk("R7 second read data", 32'(cap_d[12:4]), 32'h0B7);

    wait_cyc(20);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL R9 watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule